// File: doc/BRIEF.md
# Differential Clock Pair Stop and Power-Down Controller

This block decides, cycle by cycle, how one differential clock pair (a true leg and a complement leg) is driven while the system moves through power states. It watches the running source phase of the pair, an active-low stop pin and an active-low power-down pin, and applies a four-bit policy for the pair: enable, free-running, tristate-while-stopped and tristate-while-powered-down. For each leg it emits an encoded drive state that the analog output stage turns into a current setting.

Both pins are synchronized to the block clock. Parking happens only on source transitions so that no runt pulse reaches the pins. Stop release resumes the pair after a bounded number of source periods. Power-down release holds the pair parked for a configurable settling window.

Top module: `diff_clk_pm`

## Requirements
- R1: When the enable bit is 0, both legs report high-impedance (code 4) one clock later, regardless of pins and other policy bits.
- R2: With the free-running bit set, asserting the stop pin leaves both legs toggling (code 0).
- R3: With the free-running bit clear and the stop-tristate bit 0, an asserted stop pin parks the pair on the next rising transition of the true leg: true strong-high (code 2), complement low (code 3).
- R4: With the free-running bit clear and the stop-tristate bit 1, an asserted stop pin sets both legs to high-impedance (code 4).
- R5: Power-down engages only after the synchronized power-down pin is seen low on two consecutive complement rising edges, and then parks on the following complement falling edge; a low pulse shorter than one source period has no effect.
- R6: In power-down with the power-down-tristate bit 0, true is weak-high (code 1) and complement is high-impedance (code 4); with that bit 1, both legs are high-impedance. This holds for free-running pairs too.
- R7: After the stop pin is released, a stopped pair returns to toggling no sooner than 2 and no later than 6 source periods later, on a rising transition of the true leg.
- R8: After the power-down pin is released, the pair stays in its power-down drive for WINDOW_CYCLES clocks; if the stop pin is still asserted on a stoppable pair when the window ends, the pair moves to its stop drive, otherwise it toggles.
- R9: Out of reset, with enable 1 and the other policy bits 0, both legs report toggling (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the source clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcPhase | input | 1 | Running phase of the source clock (level of the true leg) |
| stopN | input | 1 | Active-low stop pin, asynchronous |
| pdN | input | 1 | Active-low power-down pin, asynchronous |
| cfgEnable | input | 1 | 1: pair may drive; 0: both legs high-impedance |
| cfgFreeRun | input | 1 | 1: pair ignores the stop pin |
| cfgStopTri | input | 1 | 1: high-impedance while stopped; 0: parked driven |
| cfgPdTri | input | 1 | 1: high-impedance in power-down; 0: weak-high true leg |
| trueState | output | 3 | Drive code for the true leg (0 toggle, 1 weak-high, 2 strong-high, 3 low, 4 high-impedance) |
| compState | output | 3 | Drive code for the complement leg, same coding |

## Verification
Every cycle, the assertions check the leg pairing of each parked code, the override by the enable bit, that parking into stop or power-down and the return from stop happen only on the correct source edge, that a free-running pair never enters the stop state, and that the power-down window expires only at its full count. The bench scenarios are what show the observable outcomes: the drive codes for each policy and pin combination, the ignored short power-down pulse, the measured stop-release latency in source periods, the pair held parked through the window, and the handoff into the stop drive when the stop pin outlasts power-down.

// File: rtl/diff_clk_pm_pkg.sv
package diff_clk_pm_pkg;

  typedef enum logic [2:0] {
    DRV_TOGGLE    = 3'd0,
    DRV_WEAK_HI   = 3'd1,
    DRV_STRONG_HI = 3'd2,
    DRV_LOW       = 3'd3,
    DRV_HIZ       = 3'd4
  } drive_e;

  typedef enum logic [2:0] {
    ST_RUN         = 3'd0,
    ST_STOP_PARK   = 3'd1,
    ST_STOP_RESUME = 3'd2,
    ST_PD_PARK     = 3'd3,
    ST_RESUME_WAIT = 3'd4
  } pm_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic stopPark;
    logic pdPark;
  } ctl_s;

  // synchronized events from datapath to control
  typedef struct packed {
    logic compRise;
    logic compFall;
    logic stopLow;
    logic pdLow;
  } evt_s;

endpackage

// File: rtl/diff_clk_pm_datapath.sv
module diff_clk_pm_datapath
  import diff_clk_pm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       srcPhase,
  input  logic       stopN,
  input  logic       pdN,
  input  logic       cfgEnable,
  input  logic       cfgStopTri,
  input  logic       cfgPdTri,
  input  ctl_s       ctl,
  output evt_s       evt,
  output logic [2:0] trueState,
  output logic [2:0] compState
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] stopSync;
  logic [LAST:0] pdSync;
  logic [LAST:0] phSync;
  logic          phPrev;

  // synchronizer chains, one per asynchronous input
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            stopSync[0] <= 1'b1;
            pdSync[0]   <= 1'b1;
            phSync[0]   <= 1'b0;
          end else begin
            stopSync[0] <= stopN;
            pdSync[0]   <= pdN;
            phSync[0]   <= srcPhase;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            stopSync[s] <= 1'b1;
            pdSync[s]   <= 1'b1;
            phSync[s]   <= 1'b0;
          end else begin
            stopSync[s] <= stopSync[s-1];
            pdSync[s]   <= pdSync[s-1];
            phSync[s]   <= phSync[s-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phPrev <= 1'b0;
    else       phPrev <= phSync[LAST];
  end

  // complement rises when true falls, and the reverse
  always_comb begin
    evt.compRise = phPrev & ~phSync[LAST];
    evt.compFall = ~phPrev & phSync[LAST];
    evt.stopLow  = ~stopSync[LAST];
    evt.pdLow    = ~pdSync[LAST];
  end

  drive_e trueNext;
  drive_e compNext;

  always_comb begin
    trueNext = DRV_TOGGLE;
    compNext = DRV_TOGGLE;
    if (!cfgEnable) begin
      trueNext = DRV_HIZ;
      compNext = DRV_HIZ;
    end else if (ctl.pdPark) begin
      trueNext = cfgPdTri ? DRV_HIZ : DRV_WEAK_HI;
      compNext = DRV_HIZ;
    end else if (ctl.stopPark) begin
      trueNext = cfgStopTri ? DRV_HIZ : DRV_STRONG_HI;
      compNext = cfgStopTri ? DRV_HIZ : DRV_LOW;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trueState <= DRV_TOGGLE;
      compState <= DRV_TOGGLE;
    end else begin
      trueState <= trueNext;
      compState <= compNext;
    end
  end

  // R1: disabled pair floats on both legs
  p_off_hiz_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> (trueState == DRV_HIZ && compState == DRV_HIZ));

  // R3: a strong-high true leg always pairs with a low complement
  p_park_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
    trueState == DRV_STRONG_HI |-> compState == DRV_LOW);

  // R6: weak-high true leg always pairs with a floating complement
  p_weak_pair_r6: assert property (@(posedge clk) disable iff (!rstN)
    trueState == DRV_WEAK_HI |-> compState == DRV_HIZ);

  // R2: run strobe from control yields toggling when enabled
  p_run_toggles_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && cfgEnable) |=> (trueState == DRV_TOGGLE && compState == DRV_TOGGLE));

endmodule

// File: rtl/diff_clk_pm_control.sv
module diff_clk_pm_control
  import diff_clk_pm_pkg::*;
#(
  parameter int WINDOW_CYCLES = 90000,
  parameter int RESUME_EDGES  = 3
) (
  input  logic clk,
  input  logic rstN,
  input  evt_s evt,
  input  logic cfgFreeRun,
  output ctl_s ctl
);

  localparam int WIN_W = $clog2(WINDOW_CYCLES + 1);
  localparam int REL_W = $clog2(RESUME_EDGES + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_CYCLES - 1);
  localparam logic [REL_W-1:0] REL_LAST = REL_W'(RESUME_EDGES - 1);

  pm_state_e        st, stNext;
  logic [1:0]       pdHits;
  logic [WIN_W-1:0] winCnt, winNext;
  logic [REL_W-1:0] relCnt, relNext;
  logic             stopActive;
  logic             pdArmed;

  assign stopActive = evt.stopLow & ~cfgFreeRun;
  assign pdArmed    = (pdHits == 2'd2);

  // count consecutive complement rising edges seeing power-down low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        pdHits <= 2'd0;
    else if (!evt.pdLow)              pdHits <= 2'd0;
    else if (evt.compRise && !pdArmed) pdHits <= pdHits + 2'd1;
  end

  always_comb begin
    stNext  = st;
    winNext = winCnt;
    relNext = relCnt;
    unique case (st)
      ST_RUN: begin
        if (pdArmed && evt.compFall)          stNext = ST_PD_PARK;
        else if (stopActive && evt.compFall)  stNext = ST_STOP_PARK;
      end
      ST_STOP_PARK: begin
        if (pdArmed) stNext = ST_PD_PARK;
        else if (!stopActive) begin
          stNext  = ST_STOP_RESUME;
          relNext = '0;
        end
      end
      ST_STOP_RESUME: begin
        if (pdArmed)         stNext = ST_PD_PARK;
        else if (stopActive) stNext = ST_STOP_PARK;
        else if (evt.compFall) begin
          if (relCnt == REL_LAST) stNext = ST_RUN;
          else                    relNext = relCnt + 1'b1;
        end
      end
      ST_PD_PARK: begin
        if (!evt.pdLow) begin
          stNext  = ST_RESUME_WAIT;
          winNext = '0;
        end
      end
      ST_RESUME_WAIT: begin
        if (evt.pdLow) stNext = ST_PD_PARK;
        else if (winCnt == WIN_LAST)
          stNext = stopActive ? ST_STOP_PARK : ST_RUN;
        else
          winNext = winCnt + 1'b1;
      end
      default: stNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= ST_RUN;
      winCnt <= '0;
      relCnt <= '0;
    end else begin
      st     <= stNext;
      winCnt <= winNext;
      relCnt <= relNext;
    end
  end

  always_comb begin
    ctl.run      = (st == ST_RUN);
    ctl.stopPark = (st == ST_STOP_PARK) || (st == ST_STOP_RESUME);
    ctl.pdPark   = (st == ST_PD_PARK) || (st == ST_RESUME_WAIT);
  end

  // R5: power-down parking starts only on a complement falling edge after two hits
  p_pd_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_PD_PARK && $past(st) == ST_RUN) |-> ($past(evt.compFall) && $past(pdHits) == 2'd2));

  // R3: stop parking begins on a rising transition of the true leg
  p_stop_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_STOP_PARK && $past(st) == ST_RUN) |-> $past(evt.compFall));

  // R2: a free-running pair never enters the stop state from running
  p_free_run_r2: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_RUN && cfgFreeRun) |=> (st == ST_RUN || st == ST_PD_PARK));

  // R7: stop release completes on a true-leg rising transition
  p_resume_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_RUN && $past(st) == ST_STOP_RESUME) |-> $past(evt.compFall));

  // R8: the power-down window ends only at its full count
  p_window_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(st) == ST_RESUME_WAIT && (st == ST_RUN || st == ST_STOP_PARK))
      |-> $past(winCnt) == WIN_LAST);

endmodule

// File: rtl/diff_clk_pm.sv
module diff_clk_pm
  import diff_clk_pm_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int WINDOW_CYCLES = 90000,
  parameter int RESUME_EDGES  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       srcPhase,
  input  logic       stopN,
  input  logic       pdN,
  input  logic       cfgEnable,
  input  logic       cfgFreeRun,
  input  logic       cfgStopTri,
  input  logic       cfgPdTri,
  output logic [2:0] trueState,
  output logic [2:0] compState
);

  ctl_s ctl;
  evt_s evt;

  diff_clk_pm_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .srcPhase  (srcPhase),
    .stopN     (stopN),
    .pdN       (pdN),
    .cfgEnable (cfgEnable),
    .cfgStopTri(cfgStopTri),
    .cfgPdTri  (cfgPdTri),
    .ctl       (ctl),
    .evt       (evt),
    .trueState (trueState),
    .compState (compState)
  );

  diff_clk_pm_control #(
    .WINDOW_CYCLES(WINDOW_CYCLES),
    .RESUME_EDGES (RESUME_EDGES)
  ) ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .evt       (evt),
    .cfgFreeRun(cfgFreeRun),
    .ctl       (ctl)
  );

endmodule

// File: tb/diff_clk_pm_tb_top.sv
module diff_clk_pm_tb_top;

  localparam int WIN = 40;
  localparam int SRC_HALF_NS = 80;   // source period 160 ns = 8 clocks

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       srcPhase = 1'b0;
  logic       stopN = 1'b1;
  logic       pdN = 1'b1;
  logic       cfgEnable = 1'b1;
  logic       cfgFreeRun = 1'b0;
  logic       cfgStopTri = 1'b0;
  logic       cfgPdTri = 1'b0;
  logic [2:0] trueState;
  logic [2:0] compState;

  int total = 0;
  int bad = 0;

  diff_clk_pm #(
    .SYNC_STAGES(2),
    .WINDOW_CYCLES(WIN),
    .RESUME_EDGES(3)
  ) dut_i (
    .clk(clk), .rstN(rstN), .srcPhase(srcPhase), .stopN(stopN), .pdN(pdN),
    .cfgEnable(cfgEnable), .cfgFreeRun(cfgFreeRun), .cfgStopTri(cfgStopTri),
    .cfgPdTri(cfgPdTri), .trueState(trueState), .compState(compState)
  );

  always #10 clk = ~clk;

  initial begin
    #5;
    forever #(SRC_HALF_NS) srcPhase = ~srcPhase;
  end

  // codes: 0 toggle, 1 weak-high, 2 strong-high, 3 low, 4 hi-z
  // {en, fr, stopTri, pdTri, usePd, expTrue[2:0], expComp[2:0]}
  localparam logic [10:0] VEC [9] = '{
    {5'b10000, 3'd2, 3'd3},  // R3 stop, parked driven
    {5'b10100, 3'd4, 3'd4},  // R4 stop, tristate
    {5'b11000, 3'd0, 3'd0},  // R2 free-running ignores stop
    {5'b00000, 3'd4, 3'd4},  // R1 disabled while stopped
    {5'b10001, 3'd1, 3'd4},  // R6 power-down driven
    {5'b10011, 3'd4, 3'd4},  // R6 power-down tristate
    {5'b11001, 3'd1, 3'd4},  // R6 free-running still powers down
    {5'b01011, 3'd4, 3'd4},  // R1 disabled in power-down
    {5'b11110, 3'd0, 3'd0}   // R2 free-running with tristate bits
  };

  task automatic chk(input string tag, input logic [2:0] expT, input logic [2:0] expC);
    total++;
    if (trueState !== expT || compState !== expC) begin
      bad++;
      $display("FAIL %s: got true=%0d comp=%0d expected true=%0d comp=%0d",
               tag, trueState, compState, expT, expC);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setCfg(input logic en, input logic fr, input logic st, input logic pt);
    @(negedge clk);
    cfgEnable = en; cfgFreeRun = fr; cfgStopTri = st; cfgPdTri = pt;
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitClk(3);
    @(negedge clk) rstN = 1'b1;
    waitClk(4);
    chk("R9 reset toggling", 3'd0, 3'd0);

    // vector table
    for (int i = 0; i < 9; i++) begin
      setCfg(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7]);
      waitClk(10);
      if (VEC[i][6]) pdN = 1'b0; else stopN = 1'b0;
      waitClk(60);
      chk($sformatf("vector %0d (R1/R2/R3/R4/R6)", i), VEC[i][5:3], VEC[i][2:0]);
      pdN = 1'b1; stopN = 1'b1;
      waitClk(120);
      setCfg(1'b1, 1'b0, 1'b0, 1'b0);
      waitClk(10);
      chk($sformatf("vector %0d recovery R7/R8", i), 3'd0, 3'd0);
    end

    // R1: disable with no pin activity
    setCfg(1'b0, 1'b0, 1'b0, 1'b0);
    waitClk(2);
    chk("R1 disable idle", 3'd4, 3'd4);
    setCfg(1'b1, 1'b0, 1'b0, 1'b0);
    waitClk(2);
    chk("R1 re-enable", 3'd0, 3'd0);

    // R5: short power-down pulse ignored
    @(negedge clk) pdN = 1'b0;
    waitClk(3);
    pdN = 1'b1;
    begin
      int parked = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (trueState != 3'd0) parked = 1;
      end
      total++;
      if (parked) begin
        bad++;
        $display("FAIL R5 short pulse: got parked=1 expected parked=0");
      end
    end
    chk("R5 after short pulse", 3'd0, 3'd0);

    // R7: stop release latency in source periods (8 clocks each)
    @(negedge clk) stopN = 1'b0;
    waitClk(40);
    chk("R3 stop before release", 3'd2, 3'd3);
    stopN = 1'b1;
    begin
      int lat = 0;
      while (trueState != 3'd0 && lat < 200) begin
        @(negedge clk);
        lat++;
      end
      total++;
      if (lat < 16 || lat > 48) begin
        bad++;
        $display("FAIL R7 resume latency: got %0d cycles expected 16..48", lat);
      end
    end

    // R8: resume window after power-down
    waitClk(20);
    @(negedge clk) pdN = 1'b0;
    waitClk(60);
    chk("R6 power-down", 3'd1, 3'd4);
    pdN = 1'b1;
    waitClk(20);
    chk("R8 parked inside window", 3'd1, 3'd4);
    waitClk(60);
    chk("R8 running after window", 3'd0, 3'd0);

    // R8: stop held through power-down hands off to stop drive
    @(negedge clk) begin stopN = 1'b0; pdN = 1'b0; end
    waitClk(60);
    chk("R6 power-down wins over stop", 3'd1, 3'd4);
    pdN = 1'b1;
    waitClk(80);
    chk("R8 stop drive after window", 3'd2, 3'd3);
    stopN = 1'b1;
    waitClk(60);
    chk("R7 resume after handoff", 3'd0, 3'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule